// File: doc/BRIEF.md
# Two-Slot Buffer Descriptor Tracker

This block keeps the buffer bookkeeping for one DMA channel that works on two descriptor slots in ping-pong order. Software offers a buffer through a submit port as an address and a byte size. The block checks the size against the rules of the configured channel kind. It then writes the buffer into the slot that the fill pointer selects, stores the size minus one, and marks that slot ready. The fill pointer moves to the other slot after every accepted buffer.

On the drain side, the transfer engine raises a per-slot done pulse, and can raise an error pulse with it. The drain pointer follows the slots in the same order. When the slot under the drain pointer holds a done flag, the block clears that slot's done, error and ready flags in one step. It then moves the drain pointer, logs one pending request and emits a serviced event. This repeats on every clock cycle, so two completions that arrive together are serviced on consecutive cycles.

A software service step turns one pending request into one completed buffer. Completed buffers are then removed with a detach command. Reset is asynchronous and active low; its release is expected to be synchronised to `clk` outside the block.

Top module: `bdt_pair`

## Requirements
- R1: At most two buffers are outstanding. A submit with a valid size while the queued level is 2 raises `sub_overflow` for one cycle. It leaves both slots and the level unchanged.
- R2: An accepted submit raises `sub_accept` one cycle later and loads the slot the fill pointer selects: its address, the size minus one, and its ready flag. The fill pointer starts at slot 0 after reset and toggles after each accepted submit.
- R3: The drain pointer starts at slot 0. It moves to the other slot only when the slot it points to holds a done flag. A done on the other slot waits, with that slot still ready and no serviced event, until its turn comes.
- R4: Servicing a slot clears its ready, done and error flags together. One cycle after the done flag is latched, `svc_evt` pulses with `svc_slot` naming the slot and `svc_err` showing whether an error pulse arrived for it. Two done slots are serviced on two consecutive cycles.
- R5: A `step_req` while a service request is pending lowers the level by one and raises `done_count` by one. With a pending request and level 0, it raises `step_underflow` and changes neither count. With no pending request, it does nothing.
- R6: A detach of more buffers than `done_count` raises `det_underflow` and leaves `done_count` unchanged. Otherwise `done_count` drops by `det_num`.
- R7: A submit of size 0 is rejected with `sub_badsize` for every channel kind.
- R8: For `cfg_kind` 2'b00 (control) or 2'b01 (asynchronous), a size is valid up to and including CA_MAX (2048 by default). The packet and frame settings are ignored.
- R9: For `cfg_kind` 2'b10 (isochronous), a size is valid only if it is a whole multiple of `cfg_pkt_len` and at least twice it. A packet length of 0 makes every size invalid.
- R10: For `cfg_kind` 2'b11 (synchronous), a size is valid only if it is a whole multiple of `cfg_frame_bytes` shifted left by `cfg_frame_shift`.
- R11: `sub_ready` is high exactly while the queued level is below 2.
- R12: After reset both slots are not ready, the level and `done_count` are 0, and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_kind | input | 2 | Channel kind: 00 control, 01 async, 10 isochronous, 11 synchronous |
| cfg_pkt_len | input | SIZE_W | Isochronous packet length in bytes |
| cfg_frame_bytes | input | SIZE_W | Synchronous bytes per frame |
| cfg_frame_shift | input | SHIFT_W | Left shift applied to the frame bytes |
| sub_valid | input | 1 | Submit request |
| sub_addr | input | ADDR_W | Buffer address |
| sub_size | input | SIZE_W | Buffer size in bytes |
| sub_accept | output | 1 | Pulse: submit accepted |
| sub_overflow | output | 1 | Pulse: submit refused, both slots in use |
| sub_badsize | output | 1 | Pulse: submit refused, size invalid |
| sub_ready | output | 1 | Level below 2 |
| slot_rdy | output | 2 | Ready flag of each slot |
| slot0_addr | output | ADDR_W | Slot 0 buffer address |
| slot0_len_m1 | output | SIZE_W | Slot 0 size minus one |
| slot1_addr | output | ADDR_W | Slot 1 buffer address |
| slot1_len_m1 | output | SIZE_W | Slot 1 size minus one |
| hw_done | input | 2 | Per-slot completion pulse |
| hw_err | input | 2 | Per-slot error pulse |
| svc_evt | output | 1 | Pulse: a slot was serviced |
| svc_slot | output | 1 | Slot serviced |
| svc_err | output | 1 | Serviced slot carried an error |
| step_req | input | 1 | Software service step |
| step_underflow | output | 1 | Pulse: step found level 0 |
| det_valid | input | 1 | Detach command |
| det_num | input | CNT_W | Buffers to detach |
| det_underflow | output | 1 | Pulse: detach larger than completed count |
| done_count | output | CNT_W | Completed buffers not yet detached |
| queued | output | 2 | Current level, 0 to 2 |

## Verification
A fill pointer that is out of step shows up within one cycle of the next accepted submit: the address and size appear on the wrong slot outputs. A drain pointer that is out of step shows up within two cycles of a done pulse. The serviced event names the wrong slot, or appears when a done arrives out of turn. Level or count errors show up on `queued`, `sub_ready` and `done_count` one cycle after the submit, step or detach that caused them. Spurious or missing overflow and underflow pulses show up on the same cycle. The size rules are tested at the edges of each kind's valid range.

// File: rtl/bdt_pkg.sv
package bdt_pkg;
  typedef enum logic [1:0] {
    KIND_CTRL  = 2'b00,
    KIND_ASYNC = 2'b01,
    KIND_ISOC  = 2'b10,
    KIND_SYNC  = 2'b11
  } chan_kind_e;
endpackage

// File: rtl/bdt_size_check.sv
module bdt_size_check
  import bdt_pkg::*;
#(
  parameter int SIZE_W  = 16,
  parameter int SHIFT_W = 3,
  parameter int CA_MAX  = 2048
) (
  input  logic [1:0]         kind_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [SIZE_W-1:0]  pkt_len_i,
  input  logic [SIZE_W-1:0]  frame_bytes_i,
  input  logic [SHIFT_W-1:0] frame_shift_i,
  output logic               size_ok_o
);
  localparam int UNIT_W = SIZE_W + (1 << SHIFT_W) - 1;

  logic [UNIT_W-1:0] unit;
  logic [UNIT_W-1:0] size_w;
  logic              ca_ok, isoc_ok, sync_ok;
  chan_kind_e        kind;

  always_comb begin
    kind    = chan_kind_e'(kind_i);
    unit    = UNIT_W'(frame_bytes_i) << frame_shift_i;
    size_w  = UNIT_W'(size_i);
    ca_ok   = 32'(size_i) <= 32'(CA_MAX);
    isoc_ok = (pkt_len_i != '0) && ((size_i % pkt_len_i) == '0) &&
              ({1'b0, size_i} >= {pkt_len_i, 1'b0});
    sync_ok = (unit != '0) && ((size_w % unit) == '0);
    unique case (kind)
      KIND_ISOC: size_ok_o = isoc_ok;
      KIND_SYNC: size_ok_o = sync_ok;
      default:   size_ok_o = ca_ok;
    endcase
    if (size_i == '0) size_ok_o = 1'b0;
  end
endmodule

// File: rtl/bdt_slot.sv
module bdt_slot #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] lenm1_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              clear_i,
  output logic              rdy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] lenm1_o
);
  logic rdy_d, done_d, err_d;

  always_comb begin
    rdy_d  = rdy_o;
    done_d = done_o | done_i;
    err_d  = err_o | err_i;
    if (clear_i) begin
      rdy_d  = 1'b0;
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (load_i) begin
      rdy_d  = 1'b1;
      done_d = 1'b0;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_o   <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
      lenm1_o <= '0;
    end else begin
      rdy_o  <= rdy_d;
      done_o <= done_d;
      err_o  <= err_d;
      if (load_i) begin
        addr_o  <= addr_i;
        lenm1_o <= lenm1_i;
      end
    end
  end

  assert_slot_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !load_i) |=> (!rdy_o && !done_o && !err_o));
  assert_slot_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (rdy_o && !done_o));
endmodule

// File: rtl/bdt_count.sv
module bdt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             req_i,
  input  logic             step_i,
  input  logic             det_i,
  input  logic [CNT_W-1:0] det_num_i,
  output logic [1:0]       level_o,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic             step_uflow_o,
  output logic             det_uflow_o
);
  logic [CNT_W-1:0] req_cnt, svc_cnt;
  logic [CNT_W-1:0] req_cnt_d, svc_cnt_d, done_cnt_d;
  logic [1:0]       level_d;
  logic             pending, step_act, step_take, det_ok;

  always_comb begin
    pending      = req_cnt != svc_cnt;
    step_act     = step_i & pending;
    step_uflow_o = step_act & (level_o == 2'd0);
    step_take    = step_act & (level_o != 2'd0);
    det_ok       = det_i & (det_num_i <= done_cnt_o);
    det_uflow_o  = det_i & ~det_ok;
    level_d      = level_o;
    if (accept_i && !step_take)      level_d = level_o + 2'd1;
    else if (!accept_i && step_take) level_d = level_o - 2'd1;
    req_cnt_d  = req_cnt + CNT_W'(req_i);
    svc_cnt_d  = svc_cnt + CNT_W'(step_act);
    done_cnt_d = done_cnt_o + CNT_W'(step_take) - (det_ok ? det_num_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o    <= 2'd0;
      req_cnt    <= '0;
      svc_cnt    <= '0;
      done_cnt_o <= '0;
    end else begin
      level_o    <= level_d;
      req_cnt    <= req_cnt_d;
      svc_cnt    <= svc_cnt_d;
      done_cnt_o <= done_cnt_d;
    end
  end

  assert_level_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= 2'd2);
  assert_step_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && !accept_i) |=> (level_o == $past(level_o) - 2'd1));
  assert_detach_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_uflow_o && !step_take) |=> $stable(done_cnt_o));
endmodule

// File: rtl/bdt_pair.sv
module bdt_pair #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 16,
  parameter int SHIFT_W = 3,
  parameter int CNT_W   = 8,
  parameter int CA_MAX  = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_kind,
  input  logic [SIZE_W-1:0]  cfg_pkt_len,
  input  logic [SIZE_W-1:0]  cfg_frame_bytes,
  input  logic [SHIFT_W-1:0] cfg_frame_shift,
  input  logic               sub_valid,
  input  logic [ADDR_W-1:0]  sub_addr,
  input  logic [SIZE_W-1:0]  sub_size,
  output logic               sub_accept,
  output logic               sub_overflow,
  output logic               sub_badsize,
  output logic               sub_ready,
  output logic [1:0]         slot_rdy,
  output logic [ADDR_W-1:0]  slot0_addr,
  output logic [SIZE_W-1:0]  slot0_len_m1,
  output logic [ADDR_W-1:0]  slot1_addr,
  output logic [SIZE_W-1:0]  slot1_len_m1,
  input  logic [1:0]         hw_done,
  input  logic [1:0]         hw_err,
  output logic               svc_evt,
  output logic               svc_slot,
  output logic               svc_err,
  input  logic               step_req,
  output logic               step_underflow,
  input  logic               det_valid,
  input  logic [CNT_W-1:0]   det_num,
  output logic               det_underflow,
  output logic [CNT_W-1:0]   done_count,
  output logic [1:0]         queued
);
  localparam int NSLOT = 2;

  logic              size_ok, accept, overflow, badsize, svc_fire;
  logic              fill_q, fill_d, drain_q, drain_d;
  logic              step_uflow, det_uflow;
  logic [NSLOT-1:0]  s_done, s_err;
  logic [ADDR_W-1:0] s_addr [NSLOT];
  logic [SIZE_W-1:0] s_len  [NSLOT];

  bdt_size_check #(.SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W), .CA_MAX(CA_MAX)) u_size (
    .kind_i(cfg_kind), .size_i(sub_size), .pkt_len_i(cfg_pkt_len),
    .frame_bytes_i(cfg_frame_bytes), .frame_shift_i(cfg_frame_shift),
    .size_ok_o(size_ok));

  always_comb begin
    badsize  = sub_valid & ~size_ok;
    overflow = sub_valid & size_ok & (queued == 2'd2);
    accept   = sub_valid & size_ok & (queued != 2'd2);
    svc_fire = s_done[drain_q];
    fill_d   = accept   ? ~fill_q  : fill_q;
    drain_d  = svc_fire ? ~drain_q : drain_q;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    bdt_slot #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load_i(accept && (fill_q == 1'(g))),
      .addr_i(sub_addr), .lenm1_i(sub_size - SIZE_W'(1)),
      .done_i(hw_done[g]), .err_i(hw_err[g]),
      .clear_i(svc_fire && (drain_q == 1'(g))),
      .rdy_o(slot_rdy[g]), .done_o(s_done[g]), .err_o(s_err[g]),
      .addr_o(s_addr[g]), .lenm1_o(s_len[g]));
  end

  assign slot0_addr   = s_addr[0];
  assign slot0_len_m1 = s_len[0];
  assign slot1_addr   = s_addr[1];
  assign slot1_len_m1 = s_len[1];

  bdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .req_i(svc_fire),
    .step_i(step_req), .det_i(det_valid), .det_num_i(det_num),
    .level_o(queued), .done_cnt_o(done_count),
    .step_uflow_o(step_uflow), .det_uflow_o(det_uflow));

  assign sub_ready = queued != 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q         <= 1'b0;
      drain_q        <= 1'b0;
      sub_accept     <= 1'b0;
      sub_overflow   <= 1'b0;
      sub_badsize    <= 1'b0;
      svc_evt        <= 1'b0;
      svc_slot       <= 1'b0;
      svc_err        <= 1'b0;
      step_underflow <= 1'b0;
      det_underflow  <= 1'b0;
    end else begin
      fill_q         <= fill_d;
      drain_q        <= drain_d;
      sub_accept     <= accept;
      sub_overflow   <= overflow;
      sub_badsize    <= badsize;
      svc_evt        <= svc_fire;
      svc_slot       <= drain_q;
      svc_err        <= s_err[drain_q];
      step_underflow <= step_uflow;
      det_underflow  <= det_uflow;
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && size_ok && !sub_ready) |=> (sub_overflow && !sub_accept && $stable(slot_rdy)));
  assert_fill_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_accept |-> (fill_q != $past(fill_q)));
  assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_fire |=> $stable(drain_q));
  assert_one_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sub_accept, sub_overflow, sub_badsize}));
endmodule

// File: tb/bdt_pair_bench.sv
module bdt_pair_bench;
  localparam int ADDR_W = 32, SIZE_W = 16, SHIFT_W = 3, CNT_W = 8, CA_MAX = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_kind = 2'b00;
  logic [SIZE_W-1:0] cfg_pkt_len = '0, cfg_frame_bytes = '0;
  logic [SHIFT_W-1:0] cfg_frame_shift = '0;
  logic sub_valid = 1'b0;
  logic [ADDR_W-1:0] sub_addr = '0;
  logic [SIZE_W-1:0] sub_size = '0;
  logic sub_accept, sub_overflow, sub_badsize, sub_ready;
  logic [1:0] slot_rdy;
  logic [ADDR_W-1:0] slot0_addr, slot1_addr;
  logic [SIZE_W-1:0] slot0_len_m1, slot1_len_m1;
  logic [1:0] hw_done = 2'b00, hw_err = 2'b00;
  logic svc_evt, svc_slot, svc_err;
  logic step_req = 1'b0, step_underflow;
  logic det_valid = 1'b0, det_underflow;
  logic [CNT_W-1:0] det_num = '0, done_count;
  logic [1:0] queued;

  int n_chk = 0, n_bad = 0;
  bit b_fill = 1'b0, b_drain = 1'b0;

  always #2.5 clk = ~clk;

  bdt_pair #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W),
             .CA_MAX(CA_MAX)) u_bdt_pair (.*);

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // result: 0 accept, 1 overflow, 2 bad size
  task automatic submit(string tag, logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s, int result);
    @(negedge clk);
    sub_valid = 1'b1; sub_addr = a; sub_size = s;
    @(negedge clk);
    sub_valid = 1'b0;
    chk({tag, " accept"},   sub_accept,   result == 0);
    chk({tag, " overflow"}, sub_overflow, result == 1);
    chk({tag, " badsize"},  sub_badsize,  result == 2);
    if (result == 0) begin
      chk({tag, " addr"}, b_fill ? slot1_addr : slot0_addr, a);
      chk({tag, " lenm1"}, b_fill ? slot1_len_m1 : slot0_len_m1, s - 1);
      b_fill = ~b_fill;
    end
  endtask

  task automatic pulse_done(int slot, bit e);
    @(negedge clk);
    hw_done[slot] = 1'b1; hw_err[slot] = e;
    @(negedge clk);
    hw_done = 2'b00; hw_err = 2'b00;
  endtask

  task automatic step_once();
    @(negedge clk); step_req = 1'b1;
    @(negedge clk); step_req = 1'b0;
  endtask

  task automatic detach(int n);
    @(negedge clk); det_valid = 1'b1; det_num = CNT_W'(n);
    @(negedge clk); det_valid = 1'b0;
  endtask

  task automatic retire(string tag);
    pulse_done(b_drain, 1'b0);
    @(negedge clk);
    chk({tag, " retire svc_evt"}, svc_evt, 1);
    b_drain = ~b_drain;
    step_once();
    detach(1);
    chk({tag, " retire count"}, done_count, 0);
  endtask

  task automatic t_reset();
    chk("R12 slot_rdy", slot_rdy, 0);
    chk("R12 queued", queued, 0);
    chk("R12 done_count", done_count, 0);
    chk("R12 pulses", {sub_accept, sub_overflow, sub_badsize, svc_evt, step_underflow, det_underflow}, 0);
    chk("R11 ready at reset", sub_ready, 1);
  endtask

  task automatic t_fill();
    cfg_kind = 2'b00; cfg_pkt_len = 16'd48;
    submit("R2 first", 32'h1000_0000, 16'd100, 0);
    chk("R2 slot0 ready", slot_rdy, 2'b01);
    chk("R11 ready level1", sub_ready, 1);
    submit("R2 second", 32'h2000_0040, 16'd64, 0);
    chk("R2 both ready", slot_rdy, 2'b11);
    chk("R11 not ready level2", sub_ready, 0);
    submit("R1 third", 32'h3000_0000, 16'd32, 1);
    chk("R1 slot0 kept", slot0_addr, 32'h1000_0000);
    chk("R1 slot1 kept", slot1_addr, 32'h2000_0040);
    chk("R1 level kept", queued, 2);
  endtask

  task automatic t_drain();
    pulse_done(1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 out of turn no event", svc_evt, 0);
    end
    chk("R3 slot1 still ready", slot_rdy, 2'b11);
    @(negedge clk); hw_done[0] = 1'b1; hw_err[0] = 1'b1;
    @(negedge clk); hw_done = 2'b00; hw_err = 2'b00;
    chk("R4 no event yet", svc_evt, 0);
    @(negedge clk);
    chk("R4 event slot0", svc_evt, 1);
    chk("R4 slot id 0", svc_slot, 0);
    chk("R4 err reported", svc_err, 1);
    @(negedge clk);
    chk("R4 back-to-back event", svc_evt, 1);
    chk("R4 slot id 1", svc_slot, 1);
    chk("R4 no err slot1", svc_err, 0);
    chk("R4 slots cleared", slot_rdy, 2'b00);
    @(negedge clk);
    chk("R4 single event each", svc_evt, 0);
    chk("R5 level before step", queued, 2);
    step_once();
    chk("R5 level 1", queued, 1);
    chk("R5 count 1", done_count, 1);
    chk("R11 ready again", sub_ready, 1);
    step_once();
    chk("R5 level 0", queued, 0);
    chk("R5 count 2", done_count, 2);
    step_once();
    chk("R5 idle step no underflow", step_underflow, 0);
    chk("R5 idle step count", done_count, 2);
  endtask

  task automatic t_detach();
    detach(3);
    chk("R6 underflow", det_underflow, 1);
    chk("R6 count kept", done_count, 2);
    detach(2);
    chk("R6 no underflow", det_underflow, 0);
    chk("R6 count reduced", done_count, 0);
  endtask

  task automatic t_sizes();
    cfg_kind = 2'b00;
    submit("R7 zero ctrl", 32'h10, 16'd0, 2);
    submit("R8 over max", 32'h10, 16'(CA_MAX + 1), 2);
    cfg_kind = 2'b01;
    submit("R8 at max async", 32'h4000, 16'(CA_MAX), 0);
    retire("R8");
    cfg_kind = 2'b10; cfg_pkt_len = 16'd48;
    submit("R9 one packet", 32'h20, 16'd48, 2);
    submit("R9 not multiple", 32'h20, 16'd100, 2);
    submit("R7 zero isoc", 32'h20, 16'd0, 2);
    submit("R9 two packets", 32'h5000, 16'd96, 0);
    retire("R9a");
    submit("R9 three packets", 32'h5100, 16'd144, 0);
    retire("R9b");
    cfg_pkt_len = 16'd0;
    submit("R9 zero packet len", 32'h20, 16'd96, 2);
    cfg_kind = 2'b11; cfg_frame_bytes = 16'd6; cfg_frame_shift = 3'd2;
    submit("R10 not multiple", 32'h30, 16'd30, 2);
    submit("R10 two units", 32'h6000, 16'd48, 0);
    retire("R10a");
    submit("R10 one unit", 32'h6100, 16'd24, 0);
    retire("R10b");
    submit("R7 zero sync", 32'h30, 16'd0, 2);
  endtask

  task automatic t_spurious();
    pulse_done(b_drain, 1'b0);
    @(negedge clk);
    chk("R5 spurious serviced", svc_evt, 1);
    b_drain = ~b_drain;
    @(negedge clk); step_req = 1'b1;
    @(negedge clk); step_req = 1'b0;
    chk("R5 step underflow", step_underflow, 1);
    chk("R5 underflow count kept", done_count, 0);
    chk("R5 underflow level kept", queued, 0);
    step_once();
    chk("R5 no repeat underflow", step_underflow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_drain();
    t_detach();
    t_sizes();
    t_spurious();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule